// File: doc/BRIEF.md
# Processor State and Exception-Entry Controller

This block keeps the top-level operating state of a small CPU core and sequences its entry into exception handling. It chooses among five states (reset, exception handling, bus released, program execution and power down) from two active-low reset pins, level-sensitive exception and interrupt requests, a bus request, sleep and standby commands and a wake-up input.

There are two reset flavours. The power-on pin resets everything, including the bus controller. The manual pin resets the core and leaves the bus controller out, so memory refresh keeps running. Each time the block enters exception handling it presents a branch target for one cycle. After a reset the target is a fixed vector. After an exception or interrupt it is the vector base plus the request's offset, and the current PC and SR are copied into save registers.

Top module: `cpu_state_ctrl`

## Requirements
- R1: The state output uses the codes reset=0, exception handling=1, bus released=2, program execution=3, power down=4. Exception handling always lasts exactly one cycle, and the next edge moves to program execution unless manual reset is low.
- R2: While `por_rst_n` is low the block is held in reset at once, without waiting for a clock. In that case `core_rst_o` and `busctl_rst_o` are both 1 and `new_pc_o`, `saved_pc_o` and `saved_sr_o` read 0. This also applies when both reset pins are low together.
- R3: When `man_rst_n` is low at a clock edge, the block enters reset at that edge. It then shows `core_rst_o`=1 and `busctl_rst_o`=0, and clears the target and save registers.
- R4: The first edge in reset with both pins high moves to exception handling. In that cycle `pc_load_o`=1 and `new_pc_o` equals `RESET_VEC` (default 0xA0000000).
- R5: An exception or interrupt request seen in program execution moves the block to exception handling at the next edge. `new_pc_o` then equals `vec_base` plus `vec_offset` zero-extended, taken modulo 2^ADDR_W.
- R6: On an exception or interrupt entry, `saved_pc_o` and `saved_sr_o` capture `cur_pc` and `cur_sr` as they were at that edge. They keep those values until the next such entry or reset.
- R7: A bus request in program execution, with no exception or interrupt pending, moves to bus released at the next edge. `bus_grant_o` is 1 exactly while in bus released, and the first edge with `bus_req` low returns to program execution.
- R8: While the bus is released, exception and interrupt requests are ignored: the state and the save registers do not change.
- R9: A sleep or standby command in program execution, with nothing of higher priority pending, enters power down. `pd_mode_o` reads 1 for sleep and 2 for standby, with standby chosen when both are given. It reads 0 in every other state.
- R10: In power down, an interrupt request enters exception handling with the same target and save behaviour as R5 and R6. A wake-up without an interrupt returns to program execution. Exception requests and bus requests are ignored there.
- R11: In program execution the order of precedence is manual reset, then exception or interrupt, then bus request, then power-down command.
- R12: Manual reset takes effect from every state, including bus released and power down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| man_rst_n | input | 1 | Manual reset, active low, sampled on the clock |
| exc_req | input | 1 | General exception request (level) |
| irq_req | input | 1 | Interrupt request (level) |
| vec_offset | input | VOFS_W | Vector offset supplied with the request |
| vec_base | input | ADDR_W | Vector base register value |
| cur_pc | input | ADDR_W | Current program counter |
| cur_sr | input | SR_W | Current status register |
| bus_req | input | 1 | External bus request (level) |
| sleep_cmd | input | 1 | Enter sleep |
| standby_cmd | input | 1 | Enter standby |
| wakeup | input | 1 | Leave power down without an exception |
| state_o | output | 3 | Current state code |
| core_rst_o | output | 1 | Reset to core registers and peripherals |
| busctl_rst_o | output | 1 | Reset to the bus controller |
| pc_load_o | output | 1 | New PC valid (exception-handling state) |
| new_pc_o | output | ADDR_W | Branch target |
| saved_pc_o | output | ADDR_W | Saved PC |
| saved_sr_o | output | SR_W | Saved SR |
| pd_mode_o | output | 2 | Power-down sub-mode |
| bus_grant_o | output | 1 | Bus granted |

## Verification
The hardest case to reach from the ports is an interrupt that arrives in standby or sleep and has to be vectored with its save values. Reaching it needs a chain of separate steps: a reset release, a pass through exception handling, program execution with no bus request, a power-down command, and then the interrupt. A directed sequence walks that chain with deliberately overflowing base and offset values. A long random phase with level-held bus requests and rare reset pulses then mixes manual resets into bus released and power down. A behavioural model in the bench tracks all of this, and every output is compared on every cycle.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic [2:0] {
      ST_RESET  = 3'd0,
      ST_EXC    = 3'd1,
      ST_BUSREL = 3'd2,
      ST_RUN    = 3'd3,
      ST_PDOWN  = 3'd4
   } cps_state_e;

   typedef enum logic [1:0] {
      PD_NONE  = 2'b00,
      PD_SLEEP = 2'b01,
      PD_STBY  = 2'b10
   } cps_pd_e;

   typedef enum logic {
      RK_POWERON = 1'b0,
      RK_MANUAL  = 1'b1
   } cps_rkind_e;

   typedef enum logic [1:0] {
      VS_HOLD      = 2'd0,
      VS_RESET_VEC = 2'd1,
      VS_EVENT_VEC = 2'd2,
      VS_CLEAR     = 2'd3
   } cps_vsel_e;
endpackage

// File: rtl/cps_next_state.sv
module cps_next_state
   import cps_pkg::*;
#(
   parameter bit STANDBY_WINS = 1'b1
) (
   input  cps_state_e state,
   input  cps_pd_e    pd_cur,
   input  logic       man_rst_n,
   input  logic       exc_req,
   input  logic       irq_req,
   input  logic       bus_req,
   input  logic       sleep_cmd,
   input  logic       standby_cmd,
   input  logic       wakeup,
   output cps_state_e nxt_state,
   output cps_pd_e    nxt_pd,
   output cps_vsel_e  vsel
);
   cps_pd_e pd_pick;
   logic    pd_any;

   assign pd_any = sleep_cmd | standby_cmd;

   generate
      if (STANDBY_WINS) begin : g_stby_first
         assign pd_pick = standby_cmd ? PD_STBY : PD_SLEEP;
      end else begin : g_sleep_first
         assign pd_pick = sleep_cmd ? PD_SLEEP : PD_STBY;
      end
   endgenerate

   always_comb begin
      nxt_state = state;
      nxt_pd    = PD_NONE;
      vsel      = VS_HOLD;
      if (!man_rst_n) begin
         nxt_state = ST_RESET;
         vsel      = VS_CLEAR;
      end else begin
         case (state)
            ST_RESET: begin
               nxt_state = ST_EXC;
               vsel      = VS_RESET_VEC;
            end
            ST_EXC: nxt_state = ST_RUN;
            ST_RUN: begin
               if (exc_req | irq_req) begin
                  nxt_state = ST_EXC;
                  vsel      = VS_EVENT_VEC;
               end else if (bus_req) begin
                  nxt_state = ST_BUSREL;
               end else if (pd_any) begin
                  nxt_state = ST_PDOWN;
                  nxt_pd    = pd_pick;
               end
            end
            ST_BUSREL: begin
               if (!bus_req) nxt_state = ST_RUN;
            end
            ST_PDOWN: begin
               if (irq_req) begin
                  nxt_state = ST_EXC;
                  vsel      = VS_EVENT_VEC;
               end else if (wakeup) begin
                  nxt_state = ST_RUN;
               end else begin
                  nxt_pd = pd_cur;
               end
            end
            default: begin
               nxt_state = ST_RESET;
               vsel      = VS_CLEAR;
            end
         endcase
      end
   end
endmodule

// File: rtl/cps_vector_unit.sv
module cps_vector_unit
   import cps_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          SR_W      = 32,
   parameter int          VOFS_W    = 12,
   parameter logic [63:0] RESET_VEC = 64'hA000_0000
) (
   input  logic              clk,
   input  logic              por_rst_n,
   input  cps_vsel_e         vsel,
   input  logic [ADDR_W-1:0] vec_base,
   input  logic [VOFS_W-1:0] vec_offset,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [SR_W-1:0]   cur_sr,
   output logic [ADDR_W-1:0] new_pc,
   output logic [ADDR_W-1:0] saved_pc,
   output logic [SR_W-1:0]   saved_sr
);
   localparam logic [ADDR_W-1:0] RST_TARGET = RESET_VEC[ADDR_W-1:0];

   logic [ADDR_W-1:0] ofs_ext;
   logic [ADDR_W-1:0] evt_target;

   generate
      if (VOFS_W > ADDR_W) begin : g_bad_width
         $error("cps_vector_unit: VOFS_W must not exceed ADDR_W");
      end
      if (VOFS_W == ADDR_W) begin : g_full_ofs
         assign ofs_ext = vec_offset;
      end else begin : g_ext_ofs
         assign ofs_ext = {{(ADDR_W-VOFS_W){1'b0}}, vec_offset};
      end
   endgenerate

   assign evt_target = vec_base + ofs_ext;

   always_ff @(posedge clk or negedge por_rst_n) begin
      if (!por_rst_n) begin
         new_pc   <= '0;
         saved_pc <= '0;
         saved_sr <= '0;
      end else begin
         case (vsel)
            VS_CLEAR: begin
               new_pc   <= '0;
               saved_pc <= '0;
               saved_sr <= '0;
            end
            VS_RESET_VEC: new_pc <= RST_TARGET;
            VS_EVENT_VEC: begin
               new_pc   <= evt_target;
               saved_pc <= cur_pc;
               saved_sr <= cur_sr;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cps_reset_gen.sv
module cps_reset_gen
   import cps_pkg::*;
(
   input  logic       clk,
   input  logic       por_rst_n,
   input  logic       man_rst_n,
   input  cps_state_e state,
   output logic       core_rst,
   output logic       busctl_rst
);
   cps_rkind_e kind;

   always_ff @(posedge clk or negedge por_rst_n) begin
      if (!por_rst_n)      kind <= RK_POWERON;
      else if (!man_rst_n) kind <= RK_MANUAL;
   end

   assign core_rst   = (state == ST_RESET);
   assign busctl_rst = (state == ST_RESET) && (kind == RK_POWERON);
endmodule

// File: rtl/cpu_state_ctrl.sv
module cpu_state_ctrl
   import cps_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          SR_W         = 32,
   parameter int          VOFS_W       = 12,
   parameter logic [63:0] RESET_VEC    = 64'hA000_0000,
   parameter bit          STANDBY_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              por_rst_n,
   input  logic              man_rst_n,
   input  logic              exc_req,
   input  logic              irq_req,
   input  logic [VOFS_W-1:0] vec_offset,
   input  logic [ADDR_W-1:0] vec_base,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [SR_W-1:0]   cur_sr,
   input  logic              bus_req,
   input  logic              sleep_cmd,
   input  logic              standby_cmd,
   input  logic              wakeup,
   output logic [2:0]        state_o,
   output logic              core_rst_o,
   output logic              busctl_rst_o,
   output logic              pc_load_o,
   output logic [ADDR_W-1:0] new_pc_o,
   output logic [ADDR_W-1:0] saved_pc_o,
   output logic [SR_W-1:0]   saved_sr_o,
   output logic [1:0]        pd_mode_o,
   output logic              bus_grant_o
);
   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
         $error("cpu_state_ctrl: ADDR_W out of range");
      end
      if (SR_W < 1) begin : g_bad_sr
         $error("cpu_state_ctrl: SR_W must be positive");
      end
   endgenerate

   cps_state_e state_q, state_d;
   cps_pd_e    pd_q, pd_d;
   cps_vsel_e  vsel;

   cps_next_state #(.STANDBY_WINS(STANDBY_WINS)) u_nxt (
      .state       (state_q),
      .pd_cur      (pd_q),
      .man_rst_n   (man_rst_n),
      .exc_req     (exc_req),
      .irq_req     (irq_req),
      .bus_req     (bus_req),
      .sleep_cmd   (sleep_cmd),
      .standby_cmd (standby_cmd),
      .wakeup      (wakeup),
      .nxt_state   (state_d),
      .nxt_pd      (pd_d),
      .vsel        (vsel)
   );

   always_ff @(posedge clk or negedge por_rst_n) begin
      if (!por_rst_n) begin
         state_q <= ST_RESET;
         pd_q    <= PD_NONE;
      end else begin
         state_q <= state_d;
         pd_q    <= pd_d;
      end
   end

   cps_vector_unit #(
      .ADDR_W    (ADDR_W),
      .SR_W      (SR_W),
      .VOFS_W    (VOFS_W),
      .RESET_VEC (RESET_VEC)
   ) u_vec (
      .clk        (clk),
      .por_rst_n  (por_rst_n),
      .vsel       (vsel),
      .vec_base   (vec_base),
      .vec_offset (vec_offset),
      .cur_pc     (cur_pc),
      .cur_sr     (cur_sr),
      .new_pc     (new_pc_o),
      .saved_pc   (saved_pc_o),
      .saved_sr   (saved_sr_o)
   );

   cps_reset_gen u_rst (
      .clk        (clk),
      .por_rst_n  (por_rst_n),
      .man_rst_n  (man_rst_n),
      .state      (state_q),
      .core_rst   (core_rst_o),
      .busctl_rst (busctl_rst_o)
   );

   assign state_o     = state_q;
   assign pc_load_o   = (state_q == ST_EXC);
   assign bus_grant_o = (state_q == ST_BUSREL);
   assign pd_mode_o   = pd_q;
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
   parameter int          ADDR_W    = 32,
   parameter int          SR_W      = 32,
   parameter int          VOFS_W    = 12,
   parameter logic [63:0] RESET_VEC = 64'hA000_0000
) (
   input logic              clk,
   input logic              por_rst_n,
   input logic              man_rst_n,
   input logic              exc_req,
   input logic              irq_req,
   input logic [VOFS_W-1:0] vec_offset,
   input logic [ADDR_W-1:0] vec_base,
   input logic [ADDR_W-1:0] cur_pc,
   input logic              bus_req,
   input logic [2:0]        state_o,
   input logic              core_rst_o,
   input logic              busctl_rst_o,
   input logic              pc_load_o,
   input logic [ADDR_W-1:0] new_pc_o,
   input logic [ADDR_W-1:0] saved_pc_o,
   input logic [1:0]        pd_mode_o,
   input logic              bus_grant_o
);
   logic [ADDR_W-1:0] ofs_ext;
   assign ofs_ext = ADDR_W'(vec_offset);

   // R1
   exc_one_cycle_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      (state_o == 3'd1 && man_rst_n) |=> (state_o == 3'd3));

   // R3
   manual_keeps_busctl_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      (!man_rst_n) |=> (core_rst_o && !busctl_rst_o));

   // R4
   reset_target_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      (state_o == 3'd0 && man_rst_n) |=> (pc_load_o && new_pc_o == RESET_VEC[ADDR_W-1:0]));

   // R5
   event_target_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      (state_o == 3'd3 && man_rst_n && (exc_req || irq_req))
      |=> (pc_load_o && new_pc_o == $past(vec_base + ofs_ext)));

   // R6
   save_pc_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      (state_o == 3'd3 && man_rst_n && (exc_req || irq_req))
      |=> (saved_pc_o == $past(cur_pc)));

   // R7
   grant_after_req_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      (state_o == 3'd3 && man_rst_n && !exc_req && !irq_req && bus_req) |=> bus_grant_o);

   // R8
   busrel_ignores_exc_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      (state_o == 3'd2 && man_rst_n && bus_req) |=> (bus_grant_o && $stable(saved_pc_o)));

   // R9
   pd_exclusive_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      $onehot0({bus_grant_o, pd_mode_o != 2'b00, pc_load_o, core_rst_o}));

   // R2
   busctl_within_core_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
      busctl_rst_o |-> core_rst_o);
endmodule

bind cpu_state_ctrl cps_checker #(
   .ADDR_W    (ADDR_W),
   .SR_W      (SR_W),
   .VOFS_W    (VOFS_W),
   .RESET_VEC (RESET_VEC)
) u_cps_chk (
   .clk          (clk),
   .por_rst_n    (por_rst_n),
   .man_rst_n    (man_rst_n),
   .exc_req      (exc_req),
   .irq_req      (irq_req),
   .vec_offset   (vec_offset),
   .vec_base     (vec_base),
   .cur_pc       (cur_pc),
   .bus_req      (bus_req),
   .state_o      (state_o),
   .core_rst_o   (core_rst_o),
   .busctl_rst_o (busctl_rst_o),
   .pc_load_o    (pc_load_o),
   .new_pc_o     (new_pc_o),
   .saved_pc_o   (saved_pc_o),
   .pd_mode_o    (pd_mode_o),
   .bus_grant_o  (bus_grant_o)
);

// File: tb/cpu_state_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_state_ctrl_bench;
   logic        clk = 1'b0;
   logic        por_rst_n = 1'b0, man_rst_n = 1'b1;
   logic        exc_req = 0, irq_req = 0, bus_req = 0;
   logic        sleep_cmd = 0, standby_cmd = 0, wakeup = 0;
   logic [11:0] vec_offset = '0;
   logic [31:0] vec_base = '0, cur_pc = '0, cur_sr = '0;
   logic [2:0]  state_o;
   logic        core_rst_o, busctl_rst_o, pc_load_o, bus_grant_o;
   logic [31:0] new_pc_o, saved_pc_o, saved_sr_o;
   logic [1:0]  pd_mode_o;

   int tests = 0, fails = 0;
   bit done = 0, cmp_en = 0;

   // reference model state
   int          m_state = 0, m_pd = 0;
   bit          m_manual = 0;
   logic [31:0] m_pc = '0, m_spc = '0, m_ssr = '0;

   always #2.5 clk = ~clk;

   cpu_state_ctrl u_cpu_state_ctrl (
      .clk(clk), .por_rst_n(por_rst_n), .man_rst_n(man_rst_n),
      .exc_req(exc_req), .irq_req(irq_req), .vec_offset(vec_offset),
      .vec_base(vec_base), .cur_pc(cur_pc), .cur_sr(cur_sr),
      .bus_req(bus_req), .sleep_cmd(sleep_cmd), .standby_cmd(standby_cmd),
      .wakeup(wakeup), .state_o(state_o), .core_rst_o(core_rst_o),
      .busctl_rst_o(busctl_rst_o), .pc_load_o(pc_load_o), .new_pc_o(new_pc_o),
      .saved_pc_o(saved_pc_o), .saved_sr_o(saved_sr_o), .pd_mode_o(pd_mode_o),
      .bus_grant_o(bus_grant_o));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic vector_entry();
      m_state = 1;
      m_pc  = vec_base + {20'd0, vec_offset};
      m_spc = cur_pc;
      m_ssr = cur_sr;
   endtask

   always @(posedge clk) begin
      if (!por_rst_n) begin
         m_state = 0; m_manual = 0; m_pc = '0; m_spc = '0; m_ssr = '0;
      end else if (!man_rst_n) begin
         m_state = 0; m_manual = 1; m_pc = '0; m_spc = '0; m_ssr = '0;
      end else begin
         case (m_state)
            0: begin m_state = 1; m_pc = 32'hA000_0000; end
            1: m_state = 3;
            3: begin
               if (exc_req || irq_req) vector_entry();
               else if (bus_req) m_state = 2;
               else if (standby_cmd) begin m_state = 4; m_pd = 2; end
               else if (sleep_cmd) begin m_state = 4; m_pd = 1; end
            end
            2: if (!bus_req) m_state = 3;
            4: begin
               if (irq_req) vector_entry();
               else if (wakeup) m_state = 3;
            end
            default: m_state = 0;
         endcase
      end
      if (m_state != 4) m_pd = 0;
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk("R1", "state", {29'd0, state_o}, m_state[31:0]);
         chk("R2", "core_rst", {31'd0, core_rst_o}, {31'd0, m_state == 0});
         chk("R3", "busctl_rst", {31'd0, busctl_rst_o}, {31'd0, m_state == 0 && !m_manual});
         chk("R4", "pc_load", {31'd0, pc_load_o}, {31'd0, m_state == 1});
         chk("R5", "new_pc", new_pc_o, m_pc);
         chk("R6", "saved_pc", saved_pc_o, m_spc);
         chk("R6", "saved_sr", saved_sr_o, m_ssr);
         chk("R7", "bus_grant", {31'd0, bus_grant_o}, {31'd0, m_state == 2});
         chk("R9", "pd_mode", {30'd0, pd_mode_o}, m_pd[31:0]);
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   initial begin
      tick(); tick();
      cmp_en = 1;
      tick();
      // R2: power-on reset held
      chk("R2", "por state", {29'd0, state_o}, 32'd0);
      chk("R2", "por busctl", {31'd0, busctl_rst_o}, 32'd1);
      por_rst_n = 1; tick();
      // R4: reset target
      chk("R4", "reset vector", new_pc_o, 32'hA000_0000);
      tick();
      chk("R1", "run after exc", {29'd0, state_o}, 32'd3);
      // R5 R6: exception entry
      vec_base = 32'h8000_0000; vec_offset = 12'h400;
      cur_pc = 32'h0000_1234; cur_sr = 32'h0000_00F0; exc_req = 1; tick();
      chk("R5", "exc target", new_pc_o, 32'h8000_0400);
      chk("R6", "exc spc", saved_pc_o, 32'h0000_1234);
      exc_req = 0; tick();
      // R11: exception beats bus and standby
      exc_req = 1; bus_req = 1; standby_cmd = 1; tick();
      chk("R11", "exc first", {29'd0, state_o}, 32'd1);
      exc_req = 0; tick();
      chk("R11", "run", {29'd0, state_o}, 32'd3);
      tick();
      chk("R11", "bus before pd", {29'd0, state_o}, 32'd2);
      // R8: interrupt ignored while bus released
      irq_req = 1; cur_pc = 32'h0000_9999; tick();
      chk("R8", "busrel stays", {29'd0, state_o}, 32'd2);
      chk("R8", "spc kept", saved_pc_o, 32'h0000_1234);
      irq_req = 0; bus_req = 0; tick();
      chk("R7", "return to run", {29'd0, state_o}, 32'd3);
      tick();
      chk("R9", "standby mode", {30'd0, pd_mode_o}, 32'd2);
      // R10: exc and bus ignored in power down
      standby_cmd = 0; exc_req = 1; bus_req = 1; tick();
      chk("R10", "pd stays", {29'd0, state_o}, 32'd4);
      chk("R10", "no grant", {31'd0, bus_grant_o}, 32'd0);
      exc_req = 0; bus_req = 0; wakeup = 1; tick();
      chk("R10", "wake to run", {29'd0, state_o}, 32'd3);
      wakeup = 0; sleep_cmd = 1; tick();
      chk("R9", "sleep mode", {30'd0, pd_mode_o}, 32'd1);
      sleep_cmd = 0; irq_req = 1; vec_base = 32'hFFFF_F800; vec_offset = 12'hFFF;
      cur_pc = 32'h0000_5555; tick();
      chk("R10", "irq wake target", new_pc_o, 32'h0000_07FF);
      chk("R10", "irq wake spc", saved_pc_o, 32'h0000_5555);
      irq_req = 0; tick();
      // R12 R3: manual reset from power down
      sleep_cmd = 1; tick();
      sleep_cmd = 0; man_rst_n = 0; tick();
      chk("R12", "manual from pd", {29'd0, state_o}, 32'd0);
      chk("R3", "busctl kept", {31'd0, busctl_rst_o}, 32'd0);
      chk("R3", "spc cleared", saved_pc_o, 32'd0);
      tick();
      man_rst_n = 1; tick();
      chk("R4", "manual exit vector", new_pc_o, 32'hA000_0000);
      tick();
      // R12: manual reset from bus released
      bus_req = 1; tick(); tick();
      man_rst_n = 0; tick();
      chk("R12", "manual from busrel", {29'd0, state_o}, 32'd0);
      // R2: both pins low, power-on wins
      por_rst_n = 0; tick();
      chk("R2", "both low busctl", {31'd0, busctl_rst_o}, 32'd1);
      por_rst_n = 1; man_rst_n = 1; bus_req = 0; tick();
      // random phase
      for (int i = 0; i < 6000; i++) begin
         por_rst_n   = ($urandom % 400) != 0;
         man_rst_n   = ($urandom % 90) != 0;
         exc_req     = ($urandom % 9) == 0;
         irq_req     = ($urandom % 11) == 0;
         if (($urandom % 6) == 0) bus_req = ~bus_req;
         sleep_cmd   = ($urandom % 8) == 0;
         standby_cmd = ($urandom % 12) == 0;
         wakeup      = ($urandom % 7) == 0;
         vec_base    = $urandom;
         vec_offset  = 12'($urandom);
         cur_pc      = $urandom;
         cur_sr      = $urandom;
         tick();
      end
      tick();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule